// File: doc/BRIEF.md
# Accumulator Execution Unit with Per-Opcode Flag Rules

This block is the execution datapath of a small accumulator machine. It keeps an accumulator register, an index register, a carry flag and a zero flag, plus a register that holds the data to be written to memory by a store instruction. Each cycle in which the execute strobe is high, the block applies the instruction named by a 4-bit opcode to the current registers and an 8-bit operand (memory data or an immediate value supplied by the surrounding sequencer), and the new state is visible after the next rising clock edge.

Every opcode carries its own rule for which registers are written and which flags move. Arithmetic on the accumulator updates both flags; loads, logic operations, the store and the index operations touch only the zero flag; the two compare instructions change both flags while leaving their register untouched. Instruction fetch, operand fetch and address generation belong to other blocks.

Top module: `acc_exec_unit`

## Requirements
- R1: While rst_n is low, acc_o, idx_o, store_data_o, carry_o and zero_o are all 0.
- R2: Opcodes 0x0, 0x1 and 0x2 (the three accumulator loads) with exec_i high set acc_o to the operand, set zero_o to (operand == 0) and keep carry_o.
- R3: Opcode 0x3 (store) with exec_i high sets store_data_o to the accumulator, keeps acc_o and carry_o, and sets zero_o to (accumulator == 0).
- R4: Opcode 0x4 (add) sets acc_o to (acc + operand) mod 256, carry_o to the carry out of bit 7, and zero_o to (new acc == 0).
- R5: Opcode 0x5 (subtract) sets acc_o to (acc - operand) mod 256, carry_o to 1 exactly when the unsigned operand exceeds the accumulator, and zero_o to (new acc == 0).
- R6: Opcodes 0x6 (AND) and 0x7 (OR) write the bitwise result into acc_o, set zero_o from it and keep carry_o.
- R7: Opcode 0x8 (accumulator compare) keeps acc_o, sets carry_o to (operand > acc) and zero_o to (operand == acc).
- R8: Opcode 0x9 loads idx_o with the operand; opcode 0xA increments idx_o modulo 256 (0xFF wraps to 0x00). Both set zero_o from the new index and keep carry_o.
- R9: Opcode 0xB (index compare) keeps idx_o, sets carry_o to (operand > index) and zero_o to (operand == index).
- R10: Opcodes 0xC to 0xF with exec_i high change no output.
- R11: With exec_i low, no output changes, whatever the opcode and operand.
- R12: Each instruction writes at most one of the accumulator, the index register and the store register; accumulator instructions leave idx_o unchanged and index instructions leave acc_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode of the instruction to apply |
| exec_i | input | 1 | Execute strobe; one instruction per high cycle |
| operand_i | input | 8 | Memory or immediate operand |
| acc_o | output | 8 | Accumulator register |
| idx_o | output | 8 | Index register |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |
| store_data_o | output | 8 | Data captured by the store instruction |

## Verification
The bench builds the unit with the default data width of 8 bits, so that a random operand hits the boundary values 0x00, 0xFF and "equal to the register" often enough, and the operand is further biased toward those values and toward the current accumulator. With 8 bits the carry out of an add, the borrow of a subtract or compare, and the wrap of the index increment are all reached within a few hundred random instructions, alongside directed cases for each of them, for the unused opcodes and for a low strobe.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_LDA_DIR = 4'h0,
    OP_LDA_IMM = 4'h1,
    OP_LDA_IDX = 4'h2,
    OP_STA     = 4'h3,
    OP_ADD     = 4'h4,
    OP_SUB     = 4'h5,
    OP_AND     = 4'h6,
    OP_ORA     = 4'h7,
    OP_CMP     = 4'h8,
    OP_LDX     = 4'h9,
    OP_INX     = 4'hA,
    OP_CPX     = 4'hB
  } opcode_e;

  typedef enum logic [2:0] {
    FN_PASS_OPND = 3'd0,
    FN_PASS_REG  = 3'd1,
    FN_ADD       = 3'd2,
    FN_SUB       = 3'd3,
    FN_AND       = 3'd4,
    FN_OR        = 3'd5,
    FN_INC       = 3'd6
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    src_x;
    logic    wr_acc;
    logic    wr_x;
    logic    wr_store;
    logic    upd_c;
    logic    upd_z;
  } ctrl_t;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
  import acc_exec_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_i,
  output ctrl_t          ctrl_o
);

  always_comb begin
    ctrl_o = '{fn: FN_PASS_OPND, src_x: 1'b0, wr_acc: 1'b0, wr_x: 1'b0,
               wr_store: 1'b0, upd_c: 1'b0, upd_z: 1'b0};
    case (op_i)
      OP_LDA_DIR, OP_LDA_IMM, OP_LDA_IDX: begin
        ctrl_o.fn     = FN_PASS_OPND;
        ctrl_o.wr_acc = 1'b1;
        ctrl_o.upd_z  = 1'b1;
      end
      OP_STA: begin
        ctrl_o.fn       = FN_PASS_REG;
        ctrl_o.wr_store = 1'b1;
        ctrl_o.upd_z    = 1'b1;
      end
      OP_ADD: begin
        ctrl_o.fn     = FN_ADD;
        ctrl_o.wr_acc = 1'b1;
        ctrl_o.upd_c  = 1'b1;
        ctrl_o.upd_z  = 1'b1;
      end
      OP_SUB: begin
        ctrl_o.fn     = FN_SUB;
        ctrl_o.wr_acc = 1'b1;
        ctrl_o.upd_c  = 1'b1;
        ctrl_o.upd_z  = 1'b1;
      end
      OP_AND: begin
        ctrl_o.fn     = FN_AND;
        ctrl_o.wr_acc = 1'b1;
        ctrl_o.upd_z  = 1'b1;
      end
      OP_ORA: begin
        ctrl_o.fn     = FN_OR;
        ctrl_o.wr_acc = 1'b1;
        ctrl_o.upd_z  = 1'b1;
      end
      OP_CMP: begin
        ctrl_o.fn    = FN_SUB;
        ctrl_o.upd_c = 1'b1;
        ctrl_o.upd_z = 1'b1;
      end
      OP_LDX: begin
        ctrl_o.fn    = FN_PASS_OPND;
        ctrl_o.src_x = 1'b1;
        ctrl_o.wr_x  = 1'b1;
        ctrl_o.upd_z = 1'b1;
      end
      OP_INX: begin
        ctrl_o.fn    = FN_INC;
        ctrl_o.src_x = 1'b1;
        ctrl_o.wr_x  = 1'b1;
        ctrl_o.upd_z = 1'b1;
      end
      OP_CPX: begin
        ctrl_o.fn    = FN_SUB;
        ctrl_o.src_x = 1'b1;
        ctrl_o.upd_c = 1'b1;
        ctrl_o.upd_z = 1'b1;
      end
      default: ;
    endcase
  end

  // R10: unused opcodes request no write and no flag change
  assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'hC) |-> !(ctrl_o.wr_acc || ctrl_o.wr_x || ctrl_o.wr_store ||
                         ctrl_o.upd_c || ctrl_o.upd_z));

  // R12: at most one destination register per instruction
  assert_single_dest_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_o.wr_acc, ctrl_o.wr_x, ctrl_o.wr_store}));

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
  import acc_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  alu_fn_e       fn_i,
  input  logic          src_x_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          zero_o
);

  localparam int EW = DW + 1;

  function automatic logic [EW-1:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // top bit of the widened difference is the borrow
  function automatic logic [EW-1:0] f_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  function automatic logic [DW-1:0] f_inc(input logic [DW-1:0] a);
    return a + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  logic [DW-1:0] src_val;
  logic [EW-1:0] sum_w;
  logic [EW-1:0] diff_w;

  assign src_val = src_x_i ? idx_i : acc_i;
  assign sum_w   = f_add(src_val, opnd_i);
  assign diff_w  = f_sub(src_val, opnd_i);

  always_comb begin
    res_o  = opnd_i;
    cout_o = 1'b0;
    case (fn_i)
      FN_PASS_OPND: res_o = opnd_i;
      FN_PASS_REG:  res_o = src_val;
      FN_ADD: begin
        res_o  = sum_w[DW-1:0];
        cout_o = sum_w[DW];
      end
      FN_SUB: begin
        res_o  = diff_w[DW-1:0];
        cout_o = diff_w[DW];
      end
      FN_AND:  res_o = src_val & opnd_i;
      FN_OR:   res_o = src_val | opnd_i;
      FN_INC:  res_o = f_inc(src_val);
      default: res_o = opnd_i;
    endcase
  end

  assign zero_o = (res_o == '0);

  // R5 / R7 / R9: borrow is set exactly when the operand is the larger value
  assert_borrow_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == FN_SUB) |-> (cout_o == (opnd_i > src_val)));

  // R4: an add carries out exactly when the truncated sum is below an addend
  assert_carry_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == FN_ADD) |-> (cout_o == (res_o < opnd_i)));

endmodule

// File: rtl/acc_exec_regs.sv
module acc_exec_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic          wr_acc_i,
  input  logic          wr_x_i,
  input  logic          wr_store_i,
  input  logic          upd_c_i,
  input  logic          upd_z_i,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  input  logic          zero_i,
  output logic [DW-1:0] acc_q,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] store_q,
  output logic          c_q,
  output logic          z_q
);

  logic do_acc, do_x, do_st, do_c, do_z;

  assign do_acc = exec_i & wr_acc_i;
  assign do_x   = exec_i & wr_x_i;
  assign do_st  = exec_i & wr_store_i;
  assign do_c   = exec_i & upd_c_i;
  assign do_z   = exec_i & upd_z_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      idx_q   <= '0;
      store_q <= '0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      if (do_acc) acc_q   <= res_i;
      if (do_x)   idx_q   <= res_i;
      if (do_st)  store_q <= res_i;
      if (do_c)   c_q     <= cout_i;
      if (do_z)   z_q     <= zero_i;
    end
  end

  // R11: no strobe, no state change
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> ($stable(acc_q) && $stable(idx_q) && $stable(store_q) &&
                 $stable(c_q) && $stable(z_q)));

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_i,
  input  logic           exec_i,
  input  logic [DW-1:0]  operand_i,
  output logic [DW-1:0]  acc_o,
  output logic [DW-1:0]  idx_o,
  output logic           carry_o,
  output logic           zero_o,
  output logic [DW-1:0]  store_data_o
);

  ctrl_t         ctrl;
  logic [DW-1:0] alu_res;
  logic          alu_cout;
  logic          alu_zero;

  acc_exec_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  acc_exec_alu #(.DW(DW)) u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .fn_i    (ctrl.fn),
    .src_x_i (ctrl.src_x),
    .acc_i   (acc_o),
    .idx_i   (idx_o),
    .opnd_i  (operand_i),
    .res_o   (alu_res),
    .cout_o  (alu_cout),
    .zero_o  (alu_zero)
  );

  acc_exec_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_i     (exec_i),
    .wr_acc_i   (ctrl.wr_acc),
    .wr_x_i     (ctrl.wr_x),
    .wr_store_i (ctrl.wr_store),
    .upd_c_i    (ctrl.upd_c),
    .upd_z_i    (ctrl.upd_z),
    .res_i      (alu_res),
    .cout_i     (alu_cout),
    .zero_i     (alu_zero),
    .acc_q      (acc_o),
    .idx_q      (idx_o),
    .store_q    (store_data_o),
    .c_q        (carry_o),
    .z_q        (zero_o)
  );

  assert_load_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && (op_i == OP_LDA_DIR || op_i == OP_LDA_IMM || op_i == OP_LDA_IDX))
    |=> (acc_o == $past(operand_i)) && (carry_o == $past(carry_o)) &&
        (zero_o == ($past(operand_i) == '0)));

  assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_STA)
    |=> (store_data_o == $past(acc_o)) && $stable(acc_o) &&
        (carry_o == $past(carry_o)) && (zero_o == ($past(acc_o) == '0)));

  assert_cmp_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_CMP)
    |=> $stable(acc_o) && (carry_o == ($past(operand_i) > $past(acc_o))) &&
        (zero_o == ($past(operand_i) == $past(acc_o))));

  assert_cmp_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_CPX)
    |=> $stable(idx_o) && (carry_o == ($past(operand_i) > $past(idx_o))) &&
        (zero_o == ($past(operand_i) == $past(idx_o))));

endmodule

// File: tb/tb_acc_exec_unit.sv
module tb_acc_exec_unit;

  localparam int DW = 8;
  localparam int MAXCYC = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    op_i = 4'h0;
  logic          exec_i = 1'b0;
  logic [DW-1:0] operand_i = '0;
  logic [DW-1:0] acc_o, idx_o, store_data_o;
  logic          carry_o, zero_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_acc, m_x, m_st;
  logic       m_c, m_z;

  always #5 clk = ~clk;

  acc_exec_unit #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .exec_i(exec_i),
    .operand_i(operand_i), .acc_o(acc_o), .idx_o(idx_o),
    .carry_o(carry_o), .zero_o(zero_o), .store_data_o(store_data_o)
  );

  function automatic string tag_of(input logic [3:0] op, input logic ex);
    if (!ex) return "R11";
    case (op)
      4'h0, 4'h1, 4'h2: return "R2";
      4'h3:             return "R3";
      4'h4:             return "R4";
      4'h5:             return "R5";
      4'h6, 4'h7:       return "R6";
      4'h8:             return "R7";
      4'h9, 4'hA:       return "R8";
      4'hB:             return "R9";
      default:          return "R10";
    endcase
  endfunction

  // reference model, written as integer arithmetic
  task automatic model(input logic [3:0] op, input logic [7:0] v);
    int a, x, s;
    a = m_acc; x = m_x;
    case (op)
      4'h0, 4'h1, 4'h2: begin m_acc = v; m_z = (v == 0); end
      4'h3: begin m_st = m_acc; m_z = (a == 0); end
      4'h4: begin s = a + v; m_c = (s > 255); m_acc = s % 256; m_z = (m_acc == 0); end
      4'h5: begin m_c = (v > a); m_acc = (a - v + 256) % 256; m_z = (m_acc == 0); end
      4'h6: begin m_acc = m_acc & v; m_z = (m_acc == 0); end
      4'h7: begin m_acc = m_acc | v; m_z = (m_acc == 0); end
      4'h8: begin m_c = (v > a); m_z = (v == a); end
      4'h9: begin m_x = v; m_z = (v == 0); end
      4'hA: begin m_x = (x + 1) % 256; m_z = (m_x == 0); end
      4'hB: begin m_c = (v > x); m_z = (v == x); end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag);
    total++;
    if (acc_o !== m_acc || idx_o !== m_x || store_data_o !== m_st ||
        carry_o !== m_c || zero_o !== m_z) begin
      bad++;
      $display("FAIL %s: acc=%h x=%h st=%h c=%b z=%b expected acc=%h x=%h st=%h c=%b z=%b",
               tag, acc_o, idx_o, store_data_o, carry_o, zero_o,
               m_acc, m_x, m_st, m_c, m_z);
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input logic [3:0] op, input logic [7:0] v, input logic ex,
                      input string tag);
    op_i = op; operand_i = v; exec_i = ex;
    if (ex) model(op, v);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic auto_step(input logic [3:0] op, input logic [7:0] v, input logic ex);
    step(op, v, ex, tag_of(op, ex));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; exec_i = 1'b0;
    repeat (3) @(negedge clk);
    m_acc = 0; m_x = 0; m_st = 0; m_c = 0; m_z = 0;
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(10 * MAXCYC);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20071));
    do_reset();

    // R2 / R4: add with carry out and zero result
    auto_step(4'h1, 8'hFF, 1);
    auto_step(4'h4, 8'h01, 1);
    // R3: store of zero accumulator
    auto_step(4'h3, 8'h55, 1);
    // R5: subtract with borrow
    auto_step(4'h5, 8'h01, 1);
    // R6: AND and OR hold carry
    auto_step(4'h6, 8'h0F, 1);
    auto_step(4'h7, 8'hA0, 1);
    // R7: compare equal and greater operand
    auto_step(4'h8, 8'hAF, 1);
    auto_step(4'h8, 8'hB0, 1);
    // R8: index load and wrap on increment
    auto_step(4'h9, 8'hFF, 1);
    auto_step(4'hA, 8'h00, 1);
    // R12: index op left accumulator intact, accumulator op leaves index
    step(4'hA, 8'h00, 1, "R12");
    step(4'h2, 8'h3C, 1, "R12");
    // R9: index compare
    auto_step(4'hB, 8'h01, 1);
    auto_step(4'hB, 8'h02, 1);
    // R10: unused opcodes
    for (int k = 12; k < 16; k++) auto_step(k[3:0], 8'h00, 1);
    // R11: strobe low
    auto_step(4'h4, 8'h77, 0);
    auto_step(4'h9, 8'h00, 0);

    for (int n = 0; n < 500; n++) begin
      logic [3:0] op;
      logic [7:0] v;
      logic       ex;
      op = 4'($urandom % 16);
      ex = ($urandom % 8) != 0;
      case ($urandom % 8)
        0: v = 8'h00;
        1: v = 8'hFF;
        2: v = m_acc;
        3: v = m_x;
        default: v = 8'($urandom);
      endcase
      auto_step(op, v, ex);
      if (n == 250) do_reset();
    end

    exec_i = 1'b0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule